// File: doc/BRIEF.md
# Receive Character Queue with Block-Transfer Ready Output

This block sits between a serial receiver and a host bus. Each character the receiver assembles arrives with three error flags: parity, framing and break. The block stores the character and its flags together in a 16-entry first-in first-out queue. The host reads them back oldest first. The oldest entry is always visible on the read port, and a read strobe removes it.

The block has two modes, chosen by an enable input. In queue mode it raises a level interrupt once the fill count reaches a threshold picked by a 2-bit code. It also drives an active-low ready pin for block transfers by a DMA engine. The ready pin has hysteresis: it falls when the count reaches the threshold and rises again only when the queue is completely drained. In single-register mode the block holds one character. Both the ready pin and the interrupt then follow "anything waiting".

A write that finds no room is dropped and sets a sticky overrun flag. A clear input empties the queue in one cycle.

Top module: `rxq_dma_top`

## Requirements
- R1: The queue holds up to 16 entries. `fill_cnt` gives the number stored, and `empty` is high exactly when `fill_cnt` is 0.
- R2: `rd_data`, `rd_par`, `rd_frm` and `rd_brk` show the oldest stored character and its own flags. A read strobe removes that entry, so entries come out in write order.
- R3: In queue mode, `trig_sel` codes 00, 01, 10 and 11 select thresholds of 1, 4, 8 and 14. `trig_irq` is high exactly when `fill_cnt` is at or above the selected threshold.
- R4: In queue mode, `rdy_n` goes low in the cycle in which `fill_cnt` reaches the selected threshold. Writes beyond the threshold are still accepted until the queue is full.
- R5: In queue mode, once `rdy_n` is low it stays low while `fill_cnt` is non-zero, even below the threshold. It returns high only when `fill_cnt` becomes 0.
- R6: In single-register mode (`fifo_en` = 0) the capacity is one entry. Both `rdy_n` and `trig_irq` are asserted exactly while `fill_cnt` is non-zero.
- R7: A write that finds the queue at capacity, with no read in the same cycle, is dropped and sets `ovr_flag`. `ovr_flag` stays set until a pulse on `ovr_ack`. If a new overflow occurs in the same cycle as the acknowledge, the flag stays set.
- R8: A pulse on `fifo_clr` makes `fill_cnt` 0, `empty` high and `rdy_n` high after the next edge. A write or read in that same cycle is ignored.
- R9: A read and a write in the same cycle on a full queue keep `fill_cnt` unchanged and store the new character. On an empty queue they store the character and give a count of 1.
- R10: A read strobe on an empty queue has no effect on `fill_cnt`, `empty`, `rdy_n` or `ovr_flag`.
- R11: After reset, `fill_cnt` is 0, `empty` is high, `rdy_n` is high, `trig_irq` is low and `ovr_flag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Receiver delivers a character |
| wr_data | input | 8 | Received character |
| wr_par | input | 1 | Parity error flag of the character |
| wr_frm | input | 1 | Framing error flag of the character |
| wr_brk | input | 1 | Break flag of the character |
| rd_en | input | 1 | Host read strobe; removes the oldest entry |
| fifo_en | input | 1 | 1 = 16-entry queue mode, 0 = single-register mode |
| trig_sel | input | 2 | Threshold code: 00→1, 01→4, 10→8, 11→14 |
| fifo_clr | input | 1 | Empty the queue |
| ovr_ack | input | 1 | Host acknowledges the overrun status, clearing it |
| rd_data | output | 8 | Oldest stored character |
| rd_par | output | 1 | Parity flag of the oldest entry |
| rd_frm | output | 1 | Framing flag of the oldest entry |
| rd_brk | output | 1 | Break flag of the oldest entry |
| fill_cnt | output | 5 | Number of stored entries |
| empty | output | 1 | High when nothing is stored |
| trig_irq | output | 1 | Receive-data interrupt request |
| rdy_n | output | 1 | Active-low receive-ready pin for DMA transfers |
| ovr_flag | output | 1 | Sticky overrun status |

## Verification
The read-port outputs are combinational views of stored state. They are therefore due in the same cycle as the strobe that pops them, and the bench compares them mid-cycle, before the edge that performs the read. Count, empty, interrupt, ready and overrun results are all registered, so each is due one edge after the strobe that causes it. The bench drives each stimulus one nanosecond after a rising edge, lets one edge pass, drops the strobes, and samples at the following falling edge. Each threshold code is driven to one below its level and then to the level, so that the single cycle in which the interrupt and the ready pin change is checked on its own.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  parameter int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  logic          rd_ok,
  input  logic          clr,
  input  rxq_entry_t    wr_entry,
  output rxq_entry_t    rd_entry,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt
);
  rxq_entry_t    mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_nxt;
  logic [AW-1:0] rd_ptr, rd_ptr_nxt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    cnt_nxt    = cnt;
    if (clr) begin
      wr_ptr_nxt = '0;
      rd_ptr_nxt = '0;
      cnt_nxt    = '0;
    end else begin
      if (wr_ok) wr_ptr_nxt = bump(wr_ptr);
      if (rd_ok) rd_ptr_nxt = bump(rd_ptr);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_nxt = cnt + 1'b1;
        2'b01:   cnt_nxt = cnt - 1'b1;
        default: cnt_nxt = cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      cnt    <= cnt_nxt;
    end
  end

  // One storage row per slot; the slot takes the character when it is the write target.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_ok && !clr && (wr_ptr == AW'(g));
    always_ff @(posedge clk) begin
      if (slot_we) mem[g] <= wr_entry;
    end
  end

  assign rd_entry = mem[rd_ptr];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R1

  AST_POP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ok && !wr_ok && !clr) |=> (cnt == $past(cnt) - 1'b1)); // R2
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          fifo_en,
  input  logic          clr,
  input  logic          ovr_ack,
  input  logic [CW-1:0] cnt,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic          ovr_q
);
  logic [CW-1:0] limit;
  logic          drop;
  logic          ovr_nxt;

  assign limit = fifo_en ? CW'(DEPTH) : CW'(1);

  always_comb begin
    rd_ok   = rd_en && (cnt != '0) && !clr;
    wr_ok   = wr_en && !clr && ((cnt < limit) || rd_ok);
    drop    = wr_en && !clr && !wr_ok;
    ovr_nxt = (ovr_q && !ovr_ack) || drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_nxt;
  end

  AST_EMPTY_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && rd_en && !wr_en && !clr) |=> (cnt == '0)); // R10
endmodule

// File: rtl/rxq_ready.sv
module rxq_ready #(
  parameter int DEPTH  = 16,
  parameter int TRIG_0 = 1,
  parameter int TRIG_1 = 4,
  parameter int TRIG_2 = 8,
  parameter int TRIG_3 = 14,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          clr,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cnt_nxt,
  output logic          irq,
  output logic          rdy_n
);
  logic [CW-1:0] thr;
  logic          rdy_q, rdy_nxt;

  always_comb begin
    case (trig_sel)
      2'd0:    thr = CW'(TRIG_0);
      2'd1:    thr = CW'(TRIG_1);
      2'd2:    thr = CW'(TRIG_2);
      default: thr = CW'(TRIG_3);
    endcase
  end

  always_comb begin
    if (clr)                 rdy_nxt = 1'b0;
    else if (!fifo_en)       rdy_nxt = (cnt_nxt != '0);
    else if (cnt_nxt >= thr) rdy_nxt = 1'b1;
    else if (cnt_nxt == '0)  rdy_nxt = 1'b0;
    else                     rdy_nxt = rdy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= rdy_nxt;
  end

  assign rdy_n = ~rdy_q;
  assign irq   = fifo_en ? (cnt >= thr) : (cnt != '0);

  AST_RDY_RELEASE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && $past(fifo_en) && !$past(clr) && $rose(rdy_n)) |-> (cnt == '0)); // R5

  AST_RDY_AT_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && $past(fifo_en) && !$past(clr) && cnt >= thr && $stable(trig_sel)) |-> !rdy_n); // R4
endmodule

// File: rtl/rxq_dma_top.sv
module rxq_dma_top
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TRIG_0 = 1,
  parameter int TRIG_1 = 4,
  parameter int TRIG_2 = 8,
  parameter int TRIG_3 = 14,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_par,
  input  logic              wr_frm,
  input  logic              wr_brk,
  input  logic              rd_en,
  input  logic              fifo_en,
  input  logic [1:0]        trig_sel,
  input  logic              fifo_clr,
  input  logic              ovr_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_par,
  output logic              rd_frm,
  output logic              rd_brk,
  output logic [CW-1:0]     fill_cnt,
  output logic              empty,
  output logic              trig_irq,
  output logic              rdy_n,
  output logic              ovr_flag
);
  logic          wr_ok, rd_ok;
  logic [CW-1:0] cnt, cnt_nxt;
  rxq_entry_t    wr_entry, rd_entry;

  assign wr_entry = '{brk: wr_brk, frm: wr_frm, par: wr_par, data: wr_data};

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .fifo_en(fifo_en),
    .clr(fifo_clr), .ovr_ack(ovr_ack), .cnt(cnt), .wr_ok(wr_ok), .rd_ok(rd_ok),
    .ovr_q(ovr_flag)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .rd_ok(rd_ok), .clr(fifo_clr),
    .wr_entry(wr_entry), .rd_entry(rd_entry), .cnt(cnt), .cnt_nxt(cnt_nxt)
  );

  rxq_ready #(
    .DEPTH(DEPTH), .TRIG_0(TRIG_0), .TRIG_1(TRIG_1), .TRIG_2(TRIG_2), .TRIG_3(TRIG_3)
  ) u_ready (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .clr(fifo_clr), .trig_sel(trig_sel),
    .cnt(cnt), .cnt_nxt(cnt_nxt), .irq(trig_irq), .rdy_n(rdy_n)
  );

  assign rd_data  = rd_entry.data;
  assign rd_par   = rd_entry.par;
  assign rd_frm   = rd_entry.frm;
  assign rd_brk   = rd_entry.brk;
  assign fill_cnt = cnt;
  assign empty    = (cnt == '0);

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && fill_cnt == CW'(DEPTH) && wr_en && !rd_en && !fifo_clr)
      |=> (fill_cnt == CW'(DEPTH) && ovr_flag)); // R7

  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (fill_cnt == '0 && rdy_n && empty)); // R8

  AST_RW_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == CW'(DEPTH) && wr_en && rd_en && !fifo_clr) |=> (fill_cnt == CW'(DEPTH))); // R9

  AST_SINGLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !$past(fifo_en) && !$past(fifo_clr)) |-> (rdy_n == (fill_cnt == '0))); // R6
endmodule

// File: tb/rxq_dma_top_tb_top.sv
module rxq_dma_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, fifo_en = 1'b1, fifo_clr = 1'b0, ovr_ack = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_par = 1'b0, wr_frm = 1'b0, wr_brk = 1'b0;
  logic [1:0] trig_sel = 2'd0;
  logic [7:0] rd_data;
  logic       rd_par, rd_frm, rd_brk;
  logic [4:0] fill_cnt;
  logic       empty, trig_irq, rdy_n, ovr_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [10:0] exp_q[$];
  bit          m_ovr = 0;
  bit          m_rdy = 0;
  int          seq = 0;

  always #2 clk = ~clk;

  rxq_dma_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_par(wr_par),
    .wr_frm(wr_frm), .wr_brk(wr_brk), .rd_en(rd_en), .fifo_en(fifo_en),
    .trig_sel(trig_sel), .fifo_clr(fifo_clr), .ovr_ack(ovr_ack), .rd_data(rd_data),
    .rd_par(rd_par), .rd_frm(rd_frm), .rd_brk(rd_brk), .fill_cnt(fill_cnt),
    .empty(empty), .trig_irq(trig_irq), .rdy_n(rdy_n), .ovr_flag(ovr_flag)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int thr_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  // Monitor: on a read strobe, the visible head must equal the oldest expected entry (R2)
  always @(negedge clk) begin
    if (rst_n && rd_en && !fifo_clr && exp_q.size() > 0) begin
      chk({rd_brk, rd_frm, rd_par, rd_data} == exp_q[0], "R2", "head entry",
          int'({rd_brk, rd_frm, rd_par, rd_data}), int'(exp_q[0]));
    end
  end

  // Driver: one stimulus, model update at the edge, outputs checked one edge later
  task automatic step(input bit wr, input bit rd, input bit clr, input bit ack);
    logic [10:0] ent;
    int cap, thr;
    bit rd_ok, wr_ok, drop;
    seq++;
    ent = {seq[2], seq[3], seq[1], 8'(seq * 37 + 5)};
    @(posedge clk); #1;
    wr_en = wr; rd_en = rd; fifo_clr = clr; ovr_ack = ack;
    {wr_brk, wr_frm, wr_par, wr_data} = ent;
    @(negedge clk);
    @(posedge clk);
    cap   = fifo_en ? 16 : 1;
    thr   = thr_of(trig_sel);
    rd_ok = rd && !clr && exp_q.size() > 0;
    wr_ok = wr && !clr && (exp_q.size() < cap || rd_ok);
    drop  = wr && !clr && !wr_ok;
    if (clr) exp_q.delete();
    else begin
      if (rd_ok) void'(exp_q.pop_front());
      if (wr_ok) exp_q.push_back(ent);
    end
    m_ovr = (m_ovr && !ack) || drop;
    if (clr) m_rdy = 0;
    else if (!fifo_en) m_rdy = exp_q.size() != 0;
    else if (exp_q.size() >= thr) m_rdy = 1;
    else if (exp_q.size() == 0) m_rdy = 0;
    #1;
    wr_en = 0; rd_en = 0; fifo_clr = 0; ovr_ack = 0;
    @(negedge clk);
    chk(fill_cnt == 5'(exp_q.size()), "R1", "fill_cnt", fill_cnt, exp_q.size());
    chk(empty == (exp_q.size() == 0), "R1", "empty", empty, exp_q.size() == 0);
    chk(ovr_flag == m_ovr, "R7", "ovr_flag", ovr_flag, m_ovr);
    if (fifo_en) begin
      chk(trig_irq == (exp_q.size() >= thr), "R3", "trig_irq", trig_irq, exp_q.size() >= thr);
      chk(rdy_n == !m_rdy, "R5", "rdy_n", rdy_n, !m_rdy);
    end else begin
      chk(trig_irq == (exp_q.size() != 0), "R6", "trig_irq", trig_irq, exp_q.size() != 0);
      chk(rdy_n == (exp_q.size() == 0), "R6", "rdy_n", rdy_n, exp_q.size() == 0);
    end
  endtask

  task automatic cfg(input bit fe, input logic [1:0] ts);
    @(posedge clk); #1;
    fifo_en = fe; trig_sel = ts;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(fill_cnt == 0, "R11", "fill_cnt", fill_cnt, 0);
    chk(empty == 1, "R11", "empty", empty, 1);
    chk(rdy_n == 1, "R11", "rdy_n", rdy_n, 1);
    chk(trig_irq == 0, "R11", "trig_irq", trig_irq, 0);
    chk(ovr_flag == 0, "R11", "ovr_flag", ovr_flag, 0);

    // R4/R5 hysteresis with threshold 4
    cfg(1, 2'd1);
    repeat (3) step(1, 0, 0, 0);
    chk(rdy_n == 1, "R4", "rdy_n below threshold", rdy_n, 1);
    step(1, 0, 0, 0);
    chk(rdy_n == 0, "R4", "rdy_n at threshold", rdy_n, 0);
    step(1, 0, 0, 0);
    chk(fill_cnt == 5, "R4", "accept past threshold", fill_cnt, 5);
    repeat (3) step(0, 1, 0, 0);
    chk(rdy_n == 0, "R5", "rdy_n held below threshold", rdy_n, 0);
    repeat (2) step(0, 1, 0, 0);
    chk(rdy_n == 1, "R5", "rdy_n released on empty", rdy_n, 1);
    step(0, 1, 0, 0);
    chk(fill_cnt == 0 && rdy_n == 1, "R10", "read on empty", fill_cnt, 0);

    // R3: each threshold code, one below then at level
    for (int s = 0; s < 4; s++) begin
      cfg(1, 2'(s));
      for (int k = 0; k < thr_of(2'(s)) - 1; k++) step(1, 0, 0, 0);
      chk(trig_irq == 0, "R3", "irq one below threshold", trig_irq, 0);
      step(1, 0, 0, 0);
      chk(trig_irq == 1, "R3", "irq at threshold", trig_irq, 1);
      step(0, 0, 1, 0);
    end

    // R1/R7/R9: fill, overflow, simultaneous read+write on full
    cfg(1, 2'd3);
    repeat (16) step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    chk(fill_cnt == 16 && ovr_flag == 1, "R7", "drop on full", fill_cnt, 16);
    step(1, 1, 0, 0);
    chk(fill_cnt == 16, "R9", "rd+wr on full", fill_cnt, 16);
    step(0, 0, 0, 1);
    chk(ovr_flag == 0, "R7", "ack clears overrun", ovr_flag, 0);
    step(1, 0, 0, 1);
    chk(ovr_flag == 1, "R7", "overflow wins over ack", ovr_flag, 1);
    repeat (16) step(0, 1, 0, 0);

    // R8: clear with simultaneous write
    repeat (5) step(1, 0, 0, 0);
    step(1, 0, 1, 0);
    chk(fill_cnt == 0 && rdy_n == 1 && empty == 1, "R8", "clear", fill_cnt, 0);

    // R9: read+write on empty
    step(1, 1, 0, 0);
    chk(fill_cnt == 1, "R9", "rd+wr on empty", fill_cnt, 1);
    step(0, 1, 0, 0);

    // R6: single-register mode
    cfg(0, 2'd3);
    step(1, 0, 0, 1);
    chk(rdy_n == 0 && trig_irq == 1, "R6", "single char ready", rdy_n, 0);
    step(1, 0, 0, 0);
    chk(fill_cnt == 1 && ovr_flag == 1, "R6", "capacity one", fill_cnt, 1);
    step(0, 1, 0, 1);
    chk(rdy_n == 1, "R6", "ready released", rdy_n, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule